// File: doc/BRIEF.md
# PCM Transmit Sample Queue with Debug Readback

This block holds outgoing audio samples for a PCM serial port. Software writes one 16-bit sample at a time through a single 32-bit register, and each write appends to a first-in first-out queue. A serial shift engine, outside this block, asks for the next sample with a pop request and receives it on a dedicated data port one cycle later.

The same register can also be read. A read removes the oldest sample from the queue and returns it together with a flag that tells whether real data came out. This read path exists for debug only. It competes with the shift engine for pops, and the shift engine always has priority.

The queue reports full, empty and its fill level. A write that arrives while the queue is full is discarded and sets an overrun flag, which stays set until reset.

Top module: `pcm_txq`

## Requirements
- R1: After reset, `reg_rdata` is 0, `shf_valid` is 0, `shf_data` is 0, `tx_level` is 0, `tx_empty` is 1, `tx_full` is 0 and `tx_overrun` is 0.
- R2: A register write appends `reg_wdata[15:0]` to the queue. Bits 31:16 of the write data, including the valid position at bit 16, have no effect on the stored sample.
- R3: Samples leave in the order they were written. The queue holds 32 entries. `tx_full` is 1 exactly when `tx_level` is 32, and `tx_empty` is 1 exactly when `tx_level` is 0.
- R4: A write while `tx_full` is 1 is discarded, even if a pop happens in the same cycle. It sets `tx_overrun`, which stays 1 until reset.
- R5: A pop request on a non-empty queue removes the oldest sample. In the next cycle `shf_valid` is 1 and `shf_data` holds that sample. In any cycle after a cycle with no served pop, `shf_valid` is 0 and `shf_data` is 0.
- R6: A register read that is served removes the oldest sample. From the next cycle `reg_rdata` is {15'b0, 1'b1, sample}, and the value is held until the next read.
- R7: A pop request or a register read on an empty queue leaves the level unchanged. The result is valid 0 with data 0 on the port that asked.
- R8: When a register read and a pop request occur in the same cycle, only the shift engine is served. `reg_rdata` becomes 0, with the valid bit at 16 cleared.
- R9: A write together with a served pop, on a queue that is neither empty nor full, leaves `tx_level` unchanged.
- R10: `reg_rdata[31:17]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe, one sample per cycle |
| reg_rd | input | 1 | Register read strobe (debug pop) |
| reg_wdata | input | 32 | Register write data; bits 15:0 are the sample |
| reg_rdata | output | 32 | Last register read result: bit 16 is valid, bits 15:0 are data |
| shf_pop | input | 1 | Pop request from the serial shift engine |
| shf_valid | output | 1 | A sample was delivered for the previous cycle's pop |
| shf_data | output | 16 | Sample delivered to the shift engine |
| tx_full | output | 1 | Queue holds 32 entries |
| tx_empty | output | 1 | Queue holds no entries |
| tx_overrun | output | 1 | Sticky: a write was discarded while full |
| tx_level | output | 6 | Number of stored entries |

## Verification
The debug read and the shift engine pop can fall in the same cycle. The bench provokes this by asserting `reg_rd` and `shf_pop` together, first on a queue with data and then on an empty one. It judges the result by whether the sample appears on `shf_data` with `shf_valid` set while `reg_rdata` drops to zero, and by whether the level falls by exactly one. Writes that coincide with pops are provoked in the same way on an empty, a partially filled and a full queue. In each case the level and the later drain order show whether the write was accepted.

// File: rtl/pcm_txq_pkg.sv
package pcm_txq_pkg;

  localparam int SAMPLE_W  = 16;
  localparam int REG_W     = 32;
  localparam int VALID_POS = 16;

  typedef struct packed {
    logic [REG_W-SAMPLE_W-2:0] rsvd;
    logic                      vld;
    logic [SAMPLE_W-1:0]       data;
  } reg_view_t;

  function automatic int level_next(int lvl, bit push, bit pop);
    return lvl + int'(push) - int'(pop);
  endfunction

  function automatic int ptr_step(int ptr, int depth);
    return (ptr == depth - 1) ? 0 : ptr + 1;
  endfunction

endpackage

// File: rtl/pcm_txq_arb.sv
module pcm_txq_arb (
  input  logic req_shf,
  input  logic req_bus,
  input  logic req_wr,
  input  logic q_empty,
  input  logic q_full,
  output logic serve_shf,
  output logic serve_bus,
  output logic push_ok,
  output logic push_lost
);
  always_comb begin
    serve_shf = req_shf & ~q_empty;
    serve_bus = req_bus & ~req_shf & ~q_empty;
    push_ok   = req_wr & ~q_full;
    push_lost = req_wr & q_full;
  end
endmodule

// File: rtl/pcm_txq_store.sv
module pcm_txq_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    head,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty
);
  import pcm_txq_pkg::*;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push) wr_ptr <= PTR_W'(ptr_step(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PTR_W'(ptr_step(int'(rd_ptr), DEPTH));
      level <= LVL_W'(level_next(int'(level), push, pop));
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);
endmodule

// File: rtl/pcm_txq_regif.sv
module pcm_txq_regif (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               rd_strobe,
  input  logic                               bus_served,
  input  logic                               shf_served,
  input  logic [pcm_txq_pkg::REG_W-1:0]      wdata,
  input  logic [pcm_txq_pkg::SAMPLE_W-1:0]   head,
  output logic [pcm_txq_pkg::SAMPLE_W-1:0]   sample_in,
  output logic [pcm_txq_pkg::REG_W-1:0]      rdata,
  output logic                               shf_vld,
  output logic [pcm_txq_pkg::SAMPLE_W-1:0]   shf_dat
);
  import pcm_txq_pkg::*;

  reg_view_t wr_view, rd_view;
  logic      unused_wr_hi;

  assign wr_view      = reg_view_t'(wdata);
  assign sample_in    = wr_view.data;
  assign unused_wr_hi = ^{wr_view.rsvd, wr_view.vld};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_view <= '0;
      shf_vld <= 1'b0;
      shf_dat <= '0;
    end else begin
      if (rd_strobe) begin
        rd_view.rsvd <= '0;
        rd_view.vld  <= bus_served;
        rd_view.data <= bus_served ? head : '0;
      end
      shf_vld <= shf_served;
      shf_dat <= shf_served ? head : '0;
    end
  end

  assign rdata = REG_W'(rd_view);
endmodule

// File: rtl/pcm_txq.sv
module pcm_txq #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             shf_pop,
  output logic             shf_valid,
  output logic [15:0]      shf_data,
  output logic             tx_full,
  output logic             tx_empty,
  output logic             tx_overrun,
  output logic [LVL_W-1:0] tx_level
);
  import pcm_txq_pkg::*;

  logic                serve_shf, serve_bus, push_ok, push_lost;
  logic [SAMPLE_W-1:0] sample_in, head;
  logic                ovr_q;

  pcm_txq_arb u_arb (
    .req_shf   (shf_pop),
    .req_bus   (reg_rd),
    .req_wr    (reg_wr),
    .q_empty   (tx_empty),
    .q_full    (tx_full),
    .serve_shf (serve_shf),
    .serve_bus (serve_bus),
    .push_ok   (push_ok),
    .push_lost (push_lost)
  );

  pcm_txq_store #(.DEPTH(DEPTH), .DW(SAMPLE_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ok),
    .pop   (serve_shf | serve_bus),
    .din   (sample_in),
    .head  (head),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  pcm_txq_regif u_regif (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_strobe  (reg_rd),
    .bus_served (serve_bus),
    .shf_served (serve_shf),
    .wdata      (reg_wdata),
    .head       (head),
    .sample_in  (sample_in),
    .rdata      (reg_rdata),
    .shf_vld    (shf_valid),
    .shf_dat    (shf_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovr_q <= 1'b0;
    else if (push_lost) ovr_q <= 1'b1;
  end
  assign tx_overrun = ovr_q;
endmodule

// File: rtl/pcm_txq_chk.sv
module pcm_txq_chk #(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic             shf_pop,
  input logic [31:0]      reg_rdata,
  input logic             shf_valid,
  input logic             tx_full,
  input logic             tx_empty,
  input logic             tx_overrun,
  input logic [LVL_W-1:0] tx_level,
  input logic             serve_shf,
  input logic             serve_bus,
  input logic             push_lost
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LVL_W'(DEPTH));

  p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_full && tx_empty));

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_lost |=> tx_overrun);

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |=> tx_overrun);

  p_drop_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && tx_full && !reg_rd && !shf_pop) |=> $stable(tx_level));

  p_shf_served_r5: assert property (@(posedge clk) disable iff (!rst_n)
    serve_shf |=> shf_valid);

  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_pop && tx_empty) |=> !shf_valid);

  p_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && shf_pop) |=> !reg_rdata[16]);

  p_one_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(serve_shf && serve_bus));

  p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && shf_pop && !tx_empty && !tx_full) |=> $stable(tx_level));

  p_rsvd_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[31:17] == '0);
endmodule

bind pcm_txq pcm_txq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .shf_pop    (shf_pop),
  .reg_rdata  (reg_rdata),
  .shf_valid  (shf_valid),
  .tx_full    (tx_full),
  .tx_empty   (tx_empty),
  .tx_overrun (tx_overrun),
  .tx_level   (tx_level),
  .serve_shf  (serve_shf),
  .serve_bus  (serve_bus),
  .push_lost  (push_lost)
);

// File: tb/tb_pcm_txq.sv
module tb_pcm_txq;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, shf_pop = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        shf_valid;
  logic [15:0] shf_data;
  logic        tx_full, tx_empty, tx_overrun;
  logic [5:0]  tx_level;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pcm_txq dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .shf_pop(shf_pop),
    .shf_valid(shf_valid), .shf_data(shf_data), .tx_full(tx_full),
    .tx_empty(tx_empty), .tx_overrun(tx_overrun), .tx_level(tx_level)
  );

  // vector: wr, rd, pop, wdata, exp rdata, exp shf_valid, exp shf_data, exp level
  function automatic logic [89:0] mk(logic w, logic r, logic p, logic [31:0] wd,
                                     logic [31:0] er, logic ev, logic [15:0] ed,
                                     logic [5:0] el);
    return {w, r, p, wd, er, ev, ed, el};
  endfunction

  localparam logic [89:0] VEC [NV] = '{
    mk(1,0,0,32'h0001_1234, 32'h0,          0, 16'h0,    6'd1), // R2 bit16 ignored
    mk(1,0,0,32'hFFFE_5678, 32'h0,          0, 16'h0,    6'd2), // R2 hi bits ignored
    mk(0,0,1,32'h0,         32'h0,          1, 16'h1234, 6'd1), // R5 R3 order
    mk(0,1,0,32'h0,         32'h0001_5678,  0, 16'h0,    6'd0), // R6
    mk(0,1,0,32'h0,         32'h0,          0, 16'h0,    6'd0), // R7 read empty
    mk(1,0,0,32'h0000_AAAA, 32'h0,          0, 16'h0,    6'd1), // R6 hold
    mk(1,0,1,32'h0000_0BBB, 32'h0,          1, 16'hAAAA, 6'd1), // R9
    mk(0,1,1,32'h0,         32'h0,          1, 16'h0BBB, 6'd0), // R8
    mk(1,0,1,32'h0000_00C0, 32'h0,          0, 16'h0,    6'd1), // R7 pop empty + push
    mk(0,1,0,32'h0,         32'h0001_00C0,  0, 16'h0,    6'd0), // R6
    mk(0,0,0,32'h0,         32'h0001_00C0,  0, 16'h0,    6'd0), // R6 hold, R5 idle
    mk(0,0,1,32'h0,         32'h0001_00C0,  0, 16'h0,    6'd0)  // R7 pop empty
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic p, input logic [31:0] wd);
    @(negedge clk);
    reg_wr = w; reg_rd = r; shf_pop = p; reg_wdata = wd;
    @(posedge clk);
    #1;
    reg_wr = 0; reg_rd = 0; shf_pop = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic chk_reset_state();
    chk(reg_rdata == 0, "R1 rdata", reg_rdata, 0);
    chk(shf_valid == 0 && shf_data == 0, "R1 shf", {15'b0, shf_valid, shf_data}, 0);
    chk(tx_level == 0 && tx_empty && !tx_full && !tx_overrun, "R1 flags",
        {tx_level, tx_empty, tx_full, tx_overrun}, {6'd0, 3'b100});
  endtask

  bit done = 0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    chk_reset_state();

    for (int i = 0; i < NV; i++) begin
      logic [89:0] v;
      v = VEC[i];
      cyc(v[89], v[88], v[87], v[86:55]);
      chk(reg_rdata == v[54:23], $sformatf("R6/R8 vec%0d rdata", i), reg_rdata, v[54:23]);
      chk(shf_valid == v[22] && shf_data == v[21:6], $sformatf("R5/R7 vec%0d shf", i),
          {15'b0, shf_valid, shf_data}, {15'b0, v[22], v[21:6]});
      chk(tx_level == v[5:0], $sformatf("R9/R7 vec%0d level", i),
          32'(tx_level), 32'(v[5:0]));
    end

    // R3: fill to 32
    for (int i = 0; i < 32; i++) cyc(1, 0, 0, 32'h100 + i);
    chk(tx_full && !tx_empty && tx_level == 32, "R3 full",
        {tx_full, tx_empty, tx_level}, {2'b10, 6'd32});
    chk(!tx_overrun, "R4 no overrun yet", 32'(tx_overrun), 0);
    // R4: write while full
    cyc(1, 0, 0, 32'hDEAD);
    chk(tx_level == 32 && tx_overrun, "R4 drop", {tx_level, tx_overrun}, {6'd32, 1'b1});
    // R4: write with pop while full: push still lost
    cyc(1, 0, 1, 32'hBEEF);
    chk(tx_level == 31 && shf_valid && shf_data == 16'h100, "R4 full push+pop",
        {tx_level, shf_valid, shf_data}, {6'd31, 1'b1, 16'h100});
    // R3 drain order via register reads
    for (int i = 1; i < 32; i++) begin
      cyc(0, 1, 0, 0);
      chk(reg_rdata == (32'h0001_0100 + i), "R3 order", reg_rdata, 32'h0001_0100 + i);
    end
    chk(tx_empty && tx_level == 0, "R3 empty", 32'(tx_level), 0);
    cyc(0, 0, 0, 0);
    chk(tx_overrun, "R4 sticky", 32'(tx_overrun), 1);
    // R8 on empty: both ask, nothing served
    cyc(0, 1, 1, 0);
    chk(reg_rdata == 0 && !shf_valid, "R8 empty both", {reg_rdata[16], shf_valid}, 0);

    do_reset();
    #1;
    chk_reset_state();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule